// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block controls an 8-bit general-purpose I/O port whose pins can also be lent to two serial peripherals: an asynchronous serial unit and a synchronous serial unit. Four byte-wide registers set up the port: the output data latch, the direction mask, the pullup-enable mask and the slew-enable mask. A small register bus with a 2-bit select and a one-cycle write strobe reads and writes them. For each pin the block produces a drive value, a drive enable, a pullup request and a slew control. It also takes the level sampled at the pad and passes it through a synchronizer.

Each pin belongs either to the port or to one peripheral. A pin owned by a peripheral ignores its direction bit, and the peripheral sets both its drive enable and its drive value. The pullup and slew masks still apply to peripheral-owned pins. Ownership requests are registered, so a pin changes owner one clock after the request changes. When both peripherals ask for the same pin, the asynchronous unit gets it.

Top module: `gpio_share_port`

## Requirements
- R1: After reset, all four registers read 0x00 and `padOe`, `padPull` and `padSlew` are all zero, so no pin is driven.
- R2: On a clock edge with `wrEn`=1, the register chosen by `regSel` (0 = data, 1 = direction, 2 = pullup enable, 3 = slew enable) captures all 8 bits of `wrData`. The data register captures its bits whatever the direction setting. Reading selects 1 to 3 returns the stored value.
- R3: Reading the data register (select 0) returns, for each bit, the latched data value when the port owns the pin and its direction bit is 1. For every other bit it returns the synchronized pad level.
- R4: A pin owned by the port with direction bit 1 has `padOe`=1 and `padOut` equal to its data bit. A pin owned by the port with direction bit 0 is not driven.
- R5: A pin owned by a peripheral takes `padOe` and `padOut` from that peripheral's enable and value, and its direction bit has no effect. Ownership follows `uartOwn`/`spiOwn` one clock edge after they change, and it returns to the port one edge after the request drops.
- R6: When both `uartOwn` and `spiOwn` request a pin, the asynchronous unit's enable and value drive it.
- R7: `padPull` for a pin is 1 only when its pullup-enable bit is 1, its direction bit is 0 and the pin is not being driven. This holds for port-owned pins and for peripheral-owned pins.
- R8: `padSlew` for a pin equals its slew-enable bit while the pin is driven, by the port or by a peripheral, and is 0 otherwise.
- R9: `padIn` passes through a two-flop synchronizer. `periphIn` and the data read-back show a pad change after the second clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 2 | Register select for read and write |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| padIn | input | 8 | Raw pad levels |
| periphIn | output | 8 | Synchronized pad levels for the peripherals |
| uartOwn | input | 8 | Asynchronous unit pin-ownership request |
| uartOe | input | 8 | Asynchronous unit drive enable |
| uartOut | input | 8 | Asynchronous unit drive value |
| spiOwn | input | 8 | Synchronous unit pin-ownership request |
| spiOe | input | 8 | Synchronous unit drive enable |
| spiOut | input | 8 | Synchronous unit drive value |
| padOut | output | 8 | Pad drive value |
| padOe | output | 8 | Pad drive enable |
| padPull | output | 8 | Pad pullup request |
| padSlew | output | 8 | Pad slew-rate control |

## Verification
The hardest case to reach is a pin handed from one peripheral to the other while the direction mask would make the port drive it. The port's behaviour must not show through at any point of that handover. To reach it, the bench sets the direction mask to drive every pin and gives the asynchronous unit two pins. It then raises the synchronous unit's request on the same pins and checks that the asynchronous unit keeps them. Next it drops the asynchronous request and checks that the synchronous unit takes the pins, and finally it drops that request too. At each step it samples both in the cycle before the handover and in the cycle after it, which shows the one-cycle ownership latency on both sides.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_SLEW = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrPull;
    logic wrSlew;
  } wrStb_t;
endpackage

// File: rtl/gpio_share_sync.sv
module gpio_share_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_share_ctrl.sv
module gpio_share_ctrl
  import gpio_share_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] uartOwn,
  input  logic [WIDTH-1:0] spiOwn,
  output wrStb_t           stb,
  output logic [WIDTH-1:0] uartSel,
  output logic [WIDTH-1:0] spiSel
);
  regSel_e selE;
  logic    warm;

  assign selE = regSel_e'(regSel);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (selE)
        SEL_DATA: stb.wrData = 1'b1;
        SEL_DIR:  stb.wrDir  = 1'b1;
        SEL_PULL: stb.wrPull = 1'b1;
        SEL_SLEW: stb.wrSlew = 1'b1;
        default:  stb = '0;
      endcase
    end
  end

  // Ownership arbitration, registered: asynchronous unit has priority.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uartSel <= '0;
      spiSel  <= '0;
      warm    <= 1'b0;
    end else begin
      uartSel <= uartOwn;
      spiSel  <= spiOwn & ~uartOwn;
      warm    <= 1'b1;
    end
  end

  // R6: owners never overlap on a pin
  p_owner_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (uartSel & spiSel) == '0);

  // R6: a pin requested by the asynchronous unit is granted to it next cycle
  p_uart_priority_r6: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> ((uartSel & $past(uartOwn)) == $past(uartOwn)));

  // R2: at most one write strobe per cycle
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
endmodule

// File: rtl/gpio_share_dp.sv
module gpio_share_dp
  import gpio_share_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStb_t           stb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       regSel,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] uartSel,
  input  logic [WIDTH-1:0] spiSel,
  input  logic [WIDTH-1:0] uartOe,
  input  logic [WIDTH-1:0] uartOut,
  input  logic [WIDTH-1:0] spiOe,
  input  logic [WIDTH-1:0] spiOut,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPull,
  output logic [WIDTH-1:0] padSlew,
  output logic [WIDTH-1:0] periphIn
);
  logic [WIDTH-1:0] dataReg, dirReg, pullReg, slewReg;
  logic [WIDTH-1:0] syncPad, portOwn, portDrive, dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      pullReg <= '0;
      slewReg <= '0;
    end else begin
      if (stb.wrData) dataReg <= wrData;
      if (stb.wrDir)  dirReg  <= wrData;
      if (stb.wrPull) pullReg <= wrData;
      if (stb.wrSlew) slewReg <= wrData;
    end
  end

  gpio_share_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(padIn),
    .syncOut(syncPad)
  );

  assign periphIn  = syncPad;
  assign portOwn   = ~(uartSel | spiSel);
  assign portDrive = portOwn & dirReg;
  assign dataView  = (portDrive & dataReg) | (~portDrive & syncPad);

  always_comb begin
    unique case (regSel_e'(regSel))
      SEL_DATA: rdData = dataView;
      SEL_DIR:  rdData = dirReg;
      SEL_PULL: rdData = pullReg;
      SEL_SLEW: rdData = slewReg;
      default:  rdData = '0;
    endcase
  end

  assign padOe   = portDrive | (uartSel & uartOe) | (spiSel & spiOe);
  assign padOut  = (portOwn & dataReg) | (uartSel & uartOut) | (spiSel & spiOut);
  assign padPull = pullReg & ~dirReg & ~padOe;
  assign padSlew = slewReg & padOe;

  // R7: pullup never requested on a driven pin
  p_pull_off_driven_r7: assert property (@(posedge clk) disable iff (!rstN)
    (padPull & padOe) == '0);

  // R4: an undriven port pin with direction cleared keeps its enable low
  p_port_input_hiz_r4: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & portOwn & ~dirReg) == '0);

  // R9: synchronizer latency, checked once enough edges have passed
  if (SYNC_STAGES == 2) begin : g_syncChk
    logic [1:0] warmCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 warmCnt <= '0;
      else if (warmCnt != 2'd3)  warmCnt <= warmCnt + 2'd1;
    end
    p_sync_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
      (warmCnt == 2'd3) |-> (periphIn == $past(padIn, 2)));
  end
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] periphIn,
  input  logic [WIDTH-1:0] uartOwn,
  input  logic [WIDTH-1:0] uartOe,
  input  logic [WIDTH-1:0] uartOut,
  input  logic [WIDTH-1:0] spiOwn,
  input  logic [WIDTH-1:0] spiOe,
  input  logic [WIDTH-1:0] spiOut,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPull,
  output logic [WIDTH-1:0] padSlew
);
  wrStb_t           stb;
  logic [WIDTH-1:0] uartSel, spiSel;

  gpio_share_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .wrEn   (wrEn),
    .uartOwn(uartOwn),
    .spiOwn (spiOwn),
    .stb    (stb),
    .uartSel(uartSel),
    .spiSel (spiSel)
  );

  gpio_share_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .regSel  (regSel),
    .padIn   (padIn),
    .uartSel (uartSel),
    .spiSel  (spiSel),
    .uartOe  (uartOe),
    .uartOut (uartOut),
    .spiOe   (spiOe),
    .spiOut  (spiOut),
    .rdData  (rdData),
    .padOut  (padOut),
    .padOe   (padOe),
    .padPull (padPull),
    .padSlew (padSlew),
    .periphIn(periphIn)
  );
endmodule

// File: tb/gpio_share_port_tb.sv
module gpio_share_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0, rdData, padIn = '0, periphIn;
  logic [7:0] uartOwn = '0, uartOe = '0, uartOut = '0;
  logic [7:0] spiOwn = '0, spiOe = '0, spiOut = '0;
  logic [7:0] padOut, padOe, padPull, padSlew;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  gpio_share_port u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .periphIn(periphIn),
    .uartOwn(uartOwn), .uartOe(uartOe), .uartOut(uartOut),
    .spiOwn(spiOwn), .spiOe(spiOe), .spiOut(spiOut),
    .padOut(padOut), .padOe(padOe), .padPull(padPull), .padSlew(padSlew)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] val);
    regSel = sel; wrData = val; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
    #1;
  endtask

  task automatic regRead(input string req, input logic [1:0] sel, input logic [7:0] exp);
    regSel = sel;
    #1;
    check(req, $sformatf("read sel %0d", sel), rdData, exp);
  endtask

  task automatic testReset();
    for (int s = 0; s < 4; s++) regRead("R1", 2'(s), 8'h00);
    check("R1", "padOe", padOe, 8'h00);
    check("R1", "padPull", padPull, 8'h00);
    check("R1", "padSlew", padSlew, 8'h00);
  endtask

  task automatic testRegisters();
    regWrite(2'd1, 8'hA5); regRead("R2", 2'd1, 8'hA5);
    regWrite(2'd2, 8'h3C); regRead("R2", 2'd2, 8'h3C);
    regWrite(2'd3, 8'h0F); regRead("R2", 2'd3, 8'h0F);
    regRead("R2", 2'd1, 8'hA5);
    regWrite(2'd3, 8'h00); regWrite(2'd2, 8'h00);
  endtask

  task automatic testDataLatch();
    regWrite(2'd1, 8'h00);
    padIn = 8'h00;
    regWrite(2'd0, 8'hC3);
    tick(2);
    regRead("R3", 2'd0, 8'h00);       // inputs show pad level
    check("R4", "padOe inputs", padOe, 8'h00);
    regWrite(2'd1, 8'hFF);
    regRead("R2", 2'd0, 8'hC3);       // latched while pins were inputs
    check("R4", "padOut", padOut, 8'hC3);
    check("R4", "padOe", padOe, 8'hFF);
  endtask

  task automatic testMixedRead();
    regWrite(2'd1, 8'hF0);
    regWrite(2'd0, 8'hAA);
    padIn = 8'h5C;
    tick(3);
    regRead("R3", 2'd0, 8'hAC);
    check("R9", "periphIn settled", periphIn, 8'h5C);
    padIn = 8'h33;
    tick();
    check("R9", "periphIn after one edge", periphIn, 8'h5C);
    tick();
    check("R9", "periphIn after two edges", periphIn, 8'h33);
    regRead("R9", 2'd0, 8'hA3);
  endtask

  task automatic testPullup();
    regWrite(2'd2, 8'hFF);
    check("R7", "padPull port", padPull, 8'h0F);
    check("R4", "padOe", padOe, 8'hF0);
  endtask

  task automatic testUart();
    regWrite(2'd0, 8'hFF);
    regWrite(2'd1, 8'hFF);
    regWrite(2'd3, 8'hFF);
    uartOwn = 8'h03; uartOe = 8'h01; uartOut = 8'h00;
    #1;
    check("R5", "padOe before ownership edge", padOe, 8'hFF);
    tick();
    check("R5", "padOe uart owned", padOe, 8'hFD);
    check("R5", "padOut uart owned", padOut, 8'hFC);
    check("R7", "padPull dir set", padPull, 8'h00);
    regWrite(2'd1, 8'hFC);
    check("R7", "padPull uart input pin", padPull, 8'h02);
    check("R8", "padSlew uart driven", padSlew, 8'hFD);
    regWrite(2'd3, 8'h0F);
    check("R8", "padSlew partial mask", padSlew, 8'h0D);
    regWrite(2'd3, 8'hFF);
    regWrite(2'd1, 8'hFF);
  endtask

  task automatic testConflict();
    spiOwn = 8'h03; spiOe = 8'h03; spiOut = 8'h03;
    tick();
    check("R6", "padOe conflict", padOe, 8'hFD);
    check("R6", "padOut conflict", padOut, 8'hFC);
    uartOwn = 8'h00;
    #1;
    check("R5", "padOut before handover", padOut, 8'hFC);
    tick();
    check("R6", "padOe spi takes", padOe, 8'hFF);
    check("R6", "padOut spi takes", padOut, 8'hFF);
    regWrite(2'd1, 8'hFC);
    check("R5", "dir ignored under spi", padOe, 8'hFF);
    spiOut = 8'h01;
    #1;
    check("R5", "padOut spi value", padOut, 8'hFD);
    spiOwn = 8'h00;
    #1;
    check("R5", "padOe before release", padOe, 8'hFF);
    tick();
    check("R5", "padOe after release", padOe, 8'hFC);
    check("R8", "padSlew after release", padSlew, 8'hFC);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(2);
    rstN = 1'b1;
    tick();
    testReset();
    testRegisters();
    testDataLatch();
    testMixedRead();
    testPullup();
    testUart();
    testConflict();
    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule